// File: doc/BRIEF.md
# Serial NAND Status and Feature Register Model

This block is the device side of a serial NAND flash, reduced to its status and configuration registers. It listens on a single-lane SPI link (chip select, clock, data in), decodes command bytes and answers feature reads on its data-out line. It is meant to sit in a chip-level bench or an emulation build in place of a real flash, so that a host controller's command sequences, polling loops and error handling can be run against realistic busy times and fail flags.

Every pin is oversampled in the system clock domain through a small synchroniser. The front end is a state machine with the states `SP_OPCODE` (collecting the command byte), `SP_FADDR` (collecting a feature address), `SP_ROW` (collecting row-address bytes), `SP_SETDATA` (collecting the byte to write), `SP_GETDATA` (shifting out register contents) and `SP_IGNORE` (discarding the rest of a frame). A rising chip select sends any state back to `SP_OPCODE`. A completed opcode byte moves `SP_OPCODE` to `SP_FADDR` for feature commands, to `SP_ROW` for array commands, and to `SP_IGNORE` for single-byte commands, unknown opcodes, and anything other than a feature read while the device is busy. A completed address byte moves `SP_FADDR` to `SP_GETDATA` or `SP_SETDATA`. The last byte of `SP_SETDATA` or `SP_ROW` emits an action and moves to `SP_IGNORE`. Actions go to a job machine with the states `JOB_IDLE`, `JOB_PROG`, `JOB_READ`, `JOB_ERASE` and `JOB_RESET`. An accepted array or reset command leaves `JOB_IDLE`, and each busy state returns to `JOB_IDLE` once its cycle count runs out, applying that job's completion effects.

Top module: `snand_status_model`

## Requirements
- R1: Opcode 0x06 sets the write-enable latch, status bit 1. Opcode 0x04 clears it.
- R2: A feature read is opcode 0x0F and one address byte. The register byte then follows MSB first, changing after falling clock edges (SPI mode 0). Every further byte in the same frame is a fresh copy of the register. An unknown address reads 0x00. Data-out is 0 while chip select is high.
- R3: Address 0xC0 returns status: bit 0 busy, bit 1 write-enable, bit 2 erase fail, bit 3 program fail, bits 5:4 ECC state, bits 7:6 zero. A feature write to 0xC0 has no effect.
- R4: A feature write is opcode 0x1F, one address byte and one data byte. At address 0xB0 it keeps bit 0 (quad enable) and bit 4 (ECC enable). Its other bits read 0. After power-up the register reads 0x10.
- R5: Program execute 0x10, page read 0x13 and block erase 0xD8 take three row-address bytes. These commands and reset 0xFF set the busy bit for `busy_cycles` clock cycles, at least one.
- R6: Program execute and block erase issued while write-enable is 0 have no effect: no busy time and no flag change.
- R7: An accepted program execute clears program fail. When it finishes, program fail takes the value `prog_reject` had at acceptance.
- R8: An accepted block erase clears erase fail. When it finishes, erase fail takes the value `erase_reject` had at acceptance.
- R9: Write-enable clears when a program execute or block erase finishes.
- R10: When a page read finishes, the ECC state takes the value `page_ecc` had at acceptance: 00 clean, 01 corrected, 10 uncorrectable, 11 corrected at the full capability.
- R11: Reset 0xFF clears write-enable, both fail flags and the ECC state, and leaves the configuration register unchanged.
- R12: While busy, any command other than a feature read is ignored.
- R13: A command whose frame ends, with chip select rising, before its last byte is complete has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst_n | input | 1 | Active-low asynchronous power-up reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | SPI clock, idle low |
| spi_mosi | input | 1 | Serial data into the device |
| spi_miso | output | 1 | Serial data out of the device |
| busy_cycles | input | BUSY_W | Busy duration in clk cycles (0 is treated as 1) |
| prog_reject | input | 1 | Marks the target of an accepted program execute as invalid or protected |
| erase_reject | input | 1 | Marks the target of an accepted block erase as locked |
| page_ecc | input | 2 | ECC outcome reported for an accepted page read |

## Verification
The assertions assume that the SPI clock holds each level for several system clock cycles, so that every synchronised edge is a one-cycle pulse, and that the clock is low whenever chip select changes. They also assume that the reject and ECC inputs are steady around the cycle in which a command is accepted. The bench drives each SPI half period for eight system cycles, moves chip select only while the clock is low, and sets the side inputs before it opens a frame. It samples data-out just before each rising clock edge, when the bit has long been settled.

// File: rtl/snsf_pkg.sv
package snsf_pkg;

    localparam logic [7:0] OP_WREN   = 8'h06;
    localparam logic [7:0] OP_WRDI   = 8'h04;
    localparam logic [7:0] OP_GETF   = 8'h0F;
    localparam logic [7:0] OP_SETF   = 8'h1F;
    localparam logic [7:0] OP_PEXEC  = 8'h10;
    localparam logic [7:0] OP_PREAD  = 8'h13;
    localparam logic [7:0] OP_BERASE = 8'hD8;
    localparam logic [7:0] OP_RESET  = 8'hFF;

    localparam logic [7:0] FA_STATUS = 8'hC0;
    localparam logic [7:0] FA_CONFIG = 8'hB0;
    localparam logic [7:0] CFG_MASK  = 8'h11;

    typedef enum logic [2:0] {
        ACT_WREN, ACT_WRDI, ACT_RESET, ACT_PROG, ACT_READ, ACT_ERASE, ACT_SETF
    } act_e;

    typedef enum logic [2:0] {
        SP_OPCODE, SP_FADDR, SP_ROW, SP_SETDATA, SP_GETDATA, SP_IGNORE
    } spi_st_e;

    typedef enum logic [2:0] {
        JOB_IDLE, JOB_PROG, JOB_READ, JOB_ERASE, JOB_RESET
    } job_e;

endpackage

// File: rtl/snsf_sync.sv
module snsf_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic mosi,
    output logic cs_act,
    output logic sck_rise,
    output logic sck_fall,
    output logic mosi_s
);
    localparam int TOP = STAGES - 1;

    logic [TOP:0] cs_p, sck_p, mo_p;
    logic         sck_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_p     <= '1;
            sck_p    <= '0;
            mo_p     <= '0;
            sck_last <= 1'b0;
        end else begin
            cs_p     <= {cs_p[TOP-1:0], cs_n};
            sck_p    <= {sck_p[TOP-1:0], sck};
            mo_p     <= {mo_p[TOP-1:0], mosi};
            sck_last <= sck_p[TOP];
        end
    end

    assign cs_act   = ~cs_p[TOP];
    assign sck_rise = sck_p[TOP] & ~sck_last;
    assign sck_fall = ~sck_p[TOP] & sck_last;
    assign mosi_s   = mo_p[TOP];

endmodule

// File: rtl/snsf_spi_fsm.sv
module snsf_spi_fsm
    import snsf_pkg::*;
#(
    parameter int ROW_BYTES = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_act,
    input  logic       sck_rise,
    input  logic       sck_fall,
    input  logic       mosi_s,
    input  logic       busy,
    input  logic [7:0] status_val,
    input  logic [7:0] config_val,
    output logic       act_valid,
    output act_e       act_kind,
    output logic [7:0] act_addr,
    output logic [7:0] act_data,
    output logic       miso
);
    localparam int RCW = $clog2(ROW_BYTES + 1);
    localparam logic [RCW-1:0] ROW_LAST = RCW'(ROW_BYTES - 1);

    spi_st_e        state_q, state_d;
    logic [6:0]     shin_q;
    logic [2:0]     bitcnt_q;
    logic [7:0]     opcode_q, faddr_q, shout_q, rd_val, byte_in;
    logic [RCW-1:0] rowcnt_q;
    logic           miso_q, byte_done;

    assign byte_in   = {shin_q, mosi_s};
    assign byte_done = cs_act && sck_rise && (bitcnt_q == 3'd7);
    assign act_addr  = faddr_q;
    assign act_data  = byte_in;
    assign miso      = miso_q;

    always_comb begin
        if (faddr_q == FA_STATUS)      rd_val = status_val;
        else if (faddr_q == FA_CONFIG) rd_val = config_val;
        else                           rd_val = 8'h00;
    end

    // next state and action decode
    always_comb begin
        state_d   = state_q;
        act_valid = 1'b0;
        act_kind  = ACT_WREN;
        if (byte_done) begin
            unique case (state_q)
                SP_OPCODE: begin
                    state_d = SP_IGNORE;
                    if (!busy || byte_in == OP_GETF) begin
                        case (byte_in)
                            OP_WREN:  begin act_valid = 1'b1; act_kind = ACT_WREN;  end
                            OP_WRDI:  begin act_valid = 1'b1; act_kind = ACT_WRDI;  end
                            OP_RESET: begin act_valid = 1'b1; act_kind = ACT_RESET; end
                            OP_GETF, OP_SETF:             state_d = SP_FADDR;
                            OP_PEXEC, OP_PREAD, OP_BERASE: state_d = SP_ROW;
                            default: ;
                        endcase
                    end
                end
                SP_FADDR:
                    state_d = (opcode_q == OP_GETF) ? SP_GETDATA : SP_SETDATA;
                SP_SETDATA: begin
                    act_valid = 1'b1;
                    act_kind  = ACT_SETF;
                    state_d   = SP_IGNORE;
                end
                SP_ROW: begin
                    if (rowcnt_q == ROW_LAST) begin
                        act_valid = 1'b1;
                        state_d   = SP_IGNORE;
                        if (opcode_q == OP_PEXEC)      act_kind = ACT_PROG;
                        else if (opcode_q == OP_PREAD) act_kind = ACT_READ;
                        else                           act_kind = ACT_ERASE;
                    end
                end
                SP_GETDATA: state_d = SP_GETDATA;
                SP_IGNORE:  state_d = SP_IGNORE;
                default:    state_d = SP_IGNORE;
            endcase
        end
        if (!cs_act) state_d = SP_OPCODE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SP_OPCODE;
        else        state_q <= state_d;
    end

    // shift registers, counters and data-out
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shin_q   <= '0;
            bitcnt_q <= '0;
            opcode_q <= '0;
            faddr_q  <= '0;
            shout_q  <= '0;
            rowcnt_q <= '0;
            miso_q   <= 1'b0;
        end else if (!cs_act) begin
            bitcnt_q <= '0;
            rowcnt_q <= '0;
            miso_q   <= 1'b0;
        end else begin
            if (sck_rise) begin
                shin_q   <= byte_in[6:0];
                bitcnt_q <= bitcnt_q + 3'd1;
            end
            if (byte_done && state_q == SP_OPCODE) opcode_q <= byte_in;
            if (byte_done && state_q == SP_FADDR)  faddr_q  <= byte_in;
            if (byte_done && state_q == SP_ROW)    rowcnt_q <= rowcnt_q + RCW'(1);
            if (sck_fall && state_q == SP_GETDATA) begin
                if (bitcnt_q == 3'd0) begin
                    miso_q  <= rd_val[7];
                    shout_q <= {rd_val[6:0], 1'b0};
                end else begin
                    miso_q  <= shout_q[7];
                    shout_q <= {shout_q[6:0], 1'b0};
                end
            end
        end
    end

    assert_quiet_deselect_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> !miso_q);

    assert_action_needs_select_R13: assert property (@(posedge clk) disable iff (!rst_n)
        act_valid |-> cs_act);

endmodule

// File: rtl/snsf_regs.sv
module snsf_regs
    import snsf_pkg::*;
#(
    parameter int         CNT_W    = 16,
    parameter logic [7:0] CFG_INIT = 8'h10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_valid,
    input  act_e             act_kind,
    input  logic [7:0]       act_addr,
    input  logic [7:0]       act_data,
    input  logic [CNT_W-1:0] busy_cycles,
    input  logic             prog_reject,
    input  logic             erase_reject,
    input  logic [1:0]       page_ecc,
    output logic [7:0]       status_val,
    output logic [7:0]       config_val,
    output logic             busy
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    job_e             job_q, job_d;
    logic [CNT_W-1:0] cnt_q, load;
    logic             wel_q, pfail_q, efail_q, pend_fail_q, done;
    logic [1:0]       ecc_q, pend_ecc_q;
    logic [7:0]       cfg_q;

    assign busy       = (job_q != JOB_IDLE);
    assign load       = (busy_cycles == '0) ? ONE : busy_cycles;
    assign done       = busy && (cnt_q == ONE);
    assign status_val = {2'b00, ecc_q, pfail_q, efail_q, wel_q, busy};
    assign config_val = cfg_q;

    always_comb begin
        job_d = job_q;
        unique case (job_q)
            JOB_IDLE: begin
                if (act_valid) begin
                    case (act_kind)
                        ACT_RESET: job_d = JOB_RESET;
                        ACT_READ:  job_d = JOB_READ;
                        ACT_PROG:  if (wel_q) job_d = JOB_PROG;
                        ACT_ERASE: if (wel_q) job_d = JOB_ERASE;
                        default: ;
                    endcase
                end
            end
            default: if (done) job_d = JOB_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) job_q <= JOB_IDLE;
        else        job_q <= job_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q       <= '0;
            wel_q       <= 1'b0;
            pfail_q     <= 1'b0;
            efail_q     <= 1'b0;
            pend_fail_q <= 1'b0;
            ecc_q       <= 2'b00;
            pend_ecc_q  <= 2'b00;
            cfg_q       <= CFG_INIT & CFG_MASK;
        end else begin
            if (busy) cnt_q <= cnt_q - ONE;
            if (act_valid) begin
                case (act_kind)
                    ACT_WREN: wel_q <= 1'b1;
                    ACT_WRDI: wel_q <= 1'b0;
                    ACT_RESET: begin
                        wel_q   <= 1'b0;
                        pfail_q <= 1'b0;
                        efail_q <= 1'b0;
                        ecc_q   <= 2'b00;
                        cnt_q   <= load;
                    end
                    ACT_PROG: if (wel_q) begin
                        pfail_q     <= 1'b0;
                        pend_fail_q <= prog_reject;
                        cnt_q       <= load;
                    end
                    ACT_ERASE: if (wel_q) begin
                        efail_q     <= 1'b0;
                        pend_fail_q <= erase_reject;
                        cnt_q       <= load;
                    end
                    ACT_READ: begin
                        pend_ecc_q <= page_ecc;
                        cnt_q      <= load;
                    end
                    ACT_SETF: if (act_addr == FA_CONFIG) cfg_q <= act_data & CFG_MASK;
                    default: ;
                endcase
            end
            if (done) begin
                case (job_q)
                    JOB_PROG:  begin pfail_q <= pend_fail_q; wel_q <= 1'b0; end
                    JOB_ERASE: begin efail_q <= pend_fail_q; wel_q <= 1'b0; end
                    JOB_READ:  ecc_q <= pend_ecc_q;
                    default: ;
                endcase
            end
        end
    end

    assert_wel_source_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel_q) |-> $past(act_valid && act_kind == ACT_WREN));

    assert_busy_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(act_valid && (act_kind == ACT_PROG || act_kind == ACT_READ
                                         || act_kind == ACT_ERASE || act_kind == ACT_RESET)));

    assert_locked_without_wel_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (act_valid && (act_kind == ACT_PROG || act_kind == ACT_ERASE) && !wel_q) |=> !busy);

    assert_pfail_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pfail_q) |-> $past(job_q == JOB_PROG));

    assert_efail_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(efail_q) |-> $past(job_q == JOB_ERASE));

    assert_wel_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && $past(job_q == JOB_PROG || job_q == JOB_ERASE)) |-> !wel_q);

    assert_idle_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !act_valid);

endmodule

// File: rtl/snand_status_model.sv
module snand_status_model
    import snsf_pkg::*;
#(
    parameter int         ROW_BYTES   = 3,
    parameter int         BUSY_W      = 16,
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] CFG_INIT    = 8'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_cs_n,
    input  logic              spi_sck,
    input  logic              spi_mosi,
    output logic              spi_miso,
    input  logic [BUSY_W-1:0] busy_cycles,
    input  logic              prog_reject,
    input  logic              erase_reject,
    input  logic [1:0]        page_ecc
);
    logic       cs_act, sck_rise, sck_fall, mosi_s, busy, act_valid;
    act_e       act_kind;
    logic [7:0] act_addr, act_data, status_val, config_val;

    snsf_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .cs_n(spi_cs_n), .sck(spi_sck), .mosi(spi_mosi),
        .cs_act(cs_act), .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi_s(mosi_s)
    );

    snsf_spi_fsm #(.ROW_BYTES(ROW_BYTES)) u_fsm (
        .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .sck_rise(sck_rise),
        .sck_fall(sck_fall), .mosi_s(mosi_s), .busy(busy),
        .status_val(status_val), .config_val(config_val),
        .act_valid(act_valid), .act_kind(act_kind), .act_addr(act_addr),
        .act_data(act_data), .miso(spi_miso)
    );

    snsf_regs #(.CNT_W(BUSY_W), .CFG_INIT(CFG_INIT)) u_regs (
        .clk(clk), .rst_n(rst_n), .act_valid(act_valid), .act_kind(act_kind),
        .act_addr(act_addr), .act_data(act_data), .busy_cycles(busy_cycles),
        .prog_reject(prog_reject), .erase_reject(erase_reject), .page_ecc(page_ecc),
        .status_val(status_val), .config_val(config_val), .busy(busy)
    );

endmodule

// File: tb/snand_status_model_tb.sv
module snand_status_model_tb;

    localparam int HP = 8;
    localparam int WD = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
    logic        miso;
    logic [15:0] busy_cycles = 16'd0;
    logic        prog_reject = 1'b0, erase_reject = 1'b0;
    logic [1:0]  page_ecc = 2'b00;
    int          nchk = 0, nfail = 0, cyc = 0;
    logic [63:0] rx;

    always #10 clk = ~clk;

    snand_status_model u_dut (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck), .spi_mosi(mosi),
        .spi_miso(miso), .busy_cycles(busy_cycles), .prog_reject(prog_reject),
        .erase_reject(erase_reject), .page_ecc(page_ecc)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WD) begin
            nfail = nfail + 1;
            $display("FAIL watchdog (all requirements): actual=%0d cycles expected=<%0d", cyc, WD);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check8(input string req, input logic [7:0] got, input logic [7:0] exp);
        nchk = nchk + 1;
        if (got !== exp) begin
            nfail = nfail + 1;
            $display("FAIL %s: actual=%02h expected=%02h", req, got, exp);
        end
    endtask

    // one frame: nbits of tx, left-aligned, MSB first
    task automatic frame(input int nbits, input logic [63:0] tx, output logic [63:0] rxo);
        rxo = '0;
        cs_n = 1'b0;
        for (int i = 0; i < nbits; i++) begin
            mosi = tx[63-i];
            idle(HP);
            rxo = {rxo[62:0], miso};
            sck = 1'b1;
            idle(HP);
            sck = 1'b0;
        end
        idle(2);
        cs_n = 1'b1;
        idle(2 * HP);
    endtask

    task automatic cmd1(input logic [7:0] op);
        frame(8, {op, 56'h0}, rx);
    endtask

    task automatic cmd_row(input logic [7:0] op);
        frame(32, {op, 8'h00, 8'h01, 8'h40, 32'h0}, rx);
    endtask

    task automatic get_feat(input logic [7:0] fa, output logic [7:0] val);
        frame(24, {8'h0F, fa, 48'h0}, rx);
        val = rx[7:0];
    endtask

    task automatic set_feat(input logic [7:0] fa, input logic [7:0] d);
        frame(24, {8'h1F, fa, d, 40'h0}, rx);
    endtask

    task automatic t_reset_state;
        logic [7:0] v;
        check8("R2 deselected data-out", {7'h0, miso}, 8'h00);
        get_feat(8'hC0, v);
        check8("R3 status after power-up", v, 8'h00);
        get_feat(8'hB0, v);
        check8("R4 config after power-up", v, 8'h10);
    endtask

    task automatic t_wel;
        logic [7:0] v;
        cmd1(8'h06);
        get_feat(8'hC0, v);
        check8("R1 WEL set by 0x06", v, 8'h02);
        cmd1(8'h04);
        get_feat(8'hC0, v);
        check8("R1 WEL cleared by 0x04", v, 8'h00);
    endtask

    task automatic t_features;
        logic [7:0] v;
        set_feat(8'hB0, 8'hFF);
        get_feat(8'hB0, v);
        check8("R4 config keeps bits 0 and 4", v, 8'h11);
        set_feat(8'hC0, 8'hFF);
        get_feat(8'hC0, v);
        check8("R3 status write ignored", v, 8'h00);
        get_feat(8'hA0, v);
        check8("R2 unknown address reads zero", v, 8'h00);
        check8("R2 data-out low after frame", {7'h0, miso}, 8'h00);
    endtask

    task automatic t_no_wel;
        logic [7:0] v;
        busy_cycles = 16'd3000;
        prog_reject = 1'b1;
        cmd_row(8'h10);
        get_feat(8'hC0, v);
        check8("R6 program without WEL ignored", v, 8'h00);
        erase_reject = 1'b1;
        cmd_row(8'hD8);
        get_feat(8'hC0, v);
        check8("R6 erase without WEL ignored", v, 8'h00);
        erase_reject = 1'b0;
    endtask

    task automatic t_program;
        logic [7:0] v;
        busy_cycles = 16'd3000;
        prog_reject = 1'b1;
        cmd1(8'h06);
        cmd_row(8'h10);
        get_feat(8'hC0, v);
        check8("R5 program busy with WEL", v, 8'h03);
        cmd1(8'h04);
        get_feat(8'hC0, v);
        check8("R12 WRDI ignored while busy", v, 8'h03);
        idle(3200);
        get_feat(8'hC0, v);
        check8("R7 R9 program fail set and WEL dropped", v, 8'h08);
        prog_reject = 1'b0;
        cmd1(8'h06);
        cmd_row(8'h10);
        get_feat(8'hC0, v);
        check8("R7 program fail cleared at acceptance", v, 8'h03);
        idle(3200);
        get_feat(8'hC0, v);
        check8("R7 clean program", v, 8'h00);
    endtask

    task automatic t_erase;
        logic [7:0] v;
        busy_cycles = 16'd100;
        erase_reject = 1'b1;
        cmd1(8'h06);
        cmd_row(8'hD8);
        idle(300);
        get_feat(8'hC0, v);
        check8("R8 R9 erase fail set", v, 8'h04);
        busy_cycles = 16'd3000;
        erase_reject = 1'b0;
        cmd1(8'h06);
        cmd_row(8'hD8);
        get_feat(8'hC0, v);
        check8("R8 erase fail cleared at start", v, 8'h03);
        idle(3200);
        get_feat(8'hC0, v);
        check8("R8 clean erase", v, 8'h00);
    endtask

    task automatic t_page_read;
        logic [7:0] v;
        busy_cycles = 16'd0;
        page_ecc = 2'b10;
        cmd_row(8'h13);
        get_feat(8'hC0, v);
        check8("R10 uncorrectable code, zero busy count", v, 8'h20);
        page_ecc = 2'b11;
        cmd_row(8'h13);
        get_feat(8'hC0, v);
        check8("R10 corrected at limit", v, 8'h30);
    endtask

    task automatic t_poll;
        busy_cycles = 16'd400;
        page_ecc = 2'b01;
        cmd_row(8'h13);
        frame(40, {8'h0F, 8'hC0, 48'h0}, rx);
        check8("R2 R5 first polled byte busy", rx[23:16], 8'h31);
        check8("R2 R5 third polled byte ready", rx[7:0], 8'h10);
    endtask

    task automatic t_busy_ignore;
        logic [7:0] v;
        busy_cycles = 16'd3000;
        cmd_row(8'h13);
        cmd1(8'h06);
        set_feat(8'hB0, 8'h00);
        idle(3200);
        get_feat(8'hC0, v);
        check8("R12 WREN ignored while busy", v, 8'h10);
        get_feat(8'hB0, v);
        check8("R12 feature write ignored while busy", v, 8'h11);
    endtask

    task automatic t_abort;
        logic [7:0] v;
        frame(4, {8'h06, 56'h0}, rx);
        get_feat(8'hC0, v);
        check8("R13 partial WREN aborted", v, 8'h10);
        cmd1(8'h06);
        busy_cycles = 16'd3000;
        frame(24, {8'hD8, 8'h00, 8'h01, 40'h0}, rx);
        get_feat(8'hC0, v);
        check8("R13 short erase frame aborted", v, 8'h12);
        frame(20, {8'h1F, 8'hB0, 8'h00, 40'h0}, rx);
        get_feat(8'hB0, v);
        check8("R13 partial feature write aborted", v, 8'h11);
    endtask

    task automatic t_reset_cmd;
        logic [7:0] v;
        busy_cycles = 16'd100;
        prog_reject = 1'b1;
        cmd_row(8'h10);
        idle(300);
        cmd1(8'h06);
        get_feat(8'hC0, v);
        check8("R11 setup before reset", v, 8'h1A);
        cmd1(8'hFF);
        idle(300);
        get_feat(8'hC0, v);
        check8("R11 reset clears status", v, 8'h00);
        get_feat(8'hB0, v);
        check8("R11 reset keeps config", v, 8'h11);
        prog_reject = 1'b0;
    endtask

    initial begin
        idle(5);
        rst_n = 1'b1;
        idle(5);
        t_reset_state();
        t_wel();
        t_features();
        t_no_wel();
        t_program();
        t_erase();
        t_page_read();
        t_poll();
        t_busy_ignore();
        t_abort();
        t_reset_cmd();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule